// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block lets a clocked system read and write an external asynchronous static RAM of 262,144 sixteen-bit words. The user side is a request/acknowledge port. A request carries an 18-bit word address, 16 bits of write data, a per-byte mask and a read/write flag. The request is accepted in a cycle where `rdy` is high and `req` is high. The controller then registers the request and holds it. It sequences the active-low chip, write, output and byte enables over a parameterised number of clock cycles, and signals completion with a one-cycle `ack`.

The memory data bus is shared and bidirectional, so the controller drives it only while a write is in progress. During a read it releases the bus and lets the memory drive it. Read data is captured at the end of the access window. The lanes that were not enabled are filled with zero, and the word is returned with a one-cycle `rd_valid` alongside `ack`. A write wraps its write-enable pulse with one setup cycle and one hold cycle, during which the address and data are already stable or still stable. A request with an empty byte mask finishes at once and touches no strobe.

The access window `ACC_CYC` must cover the memory's 10 ns access time at the chosen clock. For example, a 100 MHz clock needs at least one cycle.

Top module: `sramc_top`

## Requirements
- R1: After reset, and while reset is held, `sram_ce_n`, `sram_we_n`, `sram_oe_n` and both `sram_ben_n` bits are high. `sram_dq_oe`, `ack` and `rd_valid` are low, and `rdy` is high.
- R2: A write with a non-empty mask is accepted at clock edge E0. From the cycle after E0 (cycle 1) through cycle ACC_CYC+2, `sram_ce_n` is low and `sram_addr` equals the request address. `sram_we_n` is low in exactly cycles 2..ACC_CYC+1. `ack` is high in cycle ACC_CYC+2 only.
- R3: While `sram_ce_n` is low, `sram_ben_n[i]` equals the inverse of mask bit i. Mask bit 0 selects the low byte (data bits 7:0) and mask bit 1 selects the high byte (bits 15:8). A write stores only the selected bytes, and the other byte of the word keeps its previous contents.
- R4: A read with a non-empty mask is accepted at E0. `sram_oe_n` is low, `sram_ce_n` is low and `sram_we_n` is high in exactly cycles 1..ACC_CYC. `ack` and `rd_valid` are both high in cycle ACC_CYC+1 only.
- R5: In a read, `rd_data` holds the stored byte on each selected lane and zero on each unselected lane, whatever the bus carries on that lane.
- R6: `sram_dq_oe` is high only during a write's cycles 1..ACC_CYC+2, with `sram_dq_out` equal to the write data. It is never high together with a low `sram_oe_n`, and at least one clock cycle separates a read's last output-enable cycle from the next cycle in which the bus is driven.
- R7: `rdy` is low from the cycle after acceptance through the `ack` cycle. A request presented while `rdy` is low is ignored: the address and data held on the memory side do not change, and no extra access follows.
- R8: A request whose mask is 2'b00 gets `ack` in cycle 1 with `rd_valid` low. `sram_ce_n`, `sram_we_n` and `sram_oe_n` all stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request valid |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte select, bit 0 low byte, bit 1 high byte |
| rdy | output | 1 | Controller can accept a request |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | One-cycle read data valid pulse |
| rd_data | output | 16 | Captured read data, unselected lanes zero |
| sram_addr | output | 18 | Memory address |
| sram_ce_n | output | 1 | Memory chip enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_ben_n | output | 2 | Memory byte enables, active low, bit 0 low byte |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_out` |
| sram_dq_in | input | 16 | Data read from the memory bus |

## Verification
Counting from the accepting edge, an empty-mask request completes in cycle 1. A read completes, with its data, in cycle ACC_CYC+1, and a write completes in cycle ACC_CYC+2, with write enable low over cycles 2..ACC_CYC+1. The bench numbers the falling edges after acceptance and samples every strobe, the address, the bus drive, `rdy`, `ack` and `rd_data` there. Each measured cycle index is compared with these formulas. A behavioural memory that writes and reads under the strobe rules lets each stored byte be confirmed by a later masked read. That memory places a filler pattern on lanes it does not drive.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_WR,
      ST_HOLD,
      ST_RD,
      ST_DONE,
      ST_NOP
   } st_e;

   // active-high internal view of the memory strobes and user pulses
   typedef struct packed {
      logic sel;   // chip selected
      logic wr;    // write pulse
      logic rd;    // output enable
      logic drv;   // controller drives the bus
      logic ack;   // completion
      logic rv;    // read data valid
   } strobe_t;

   function automatic strobe_t decode_strobes(st_e s);
      strobe_t t;
      t = '0;
      case (s)
         ST_SETUP: begin t.sel = 1'b1; t.drv = 1'b1; end
         ST_WR:    begin t.sel = 1'b1; t.drv = 1'b1; t.wr = 1'b1; end
         ST_HOLD:  begin t.sel = 1'b1; t.drv = 1'b1; t.ack = 1'b1; end
         ST_RD:    begin t.sel = 1'b1; t.rd = 1'b1; end
         ST_DONE:  begin t.ack = 1'b1; t.rv = 1'b1; end
         ST_NOP:   begin t.ack = 1'b1; end
         default:  t = '0;
      endcase
      return t;
   endfunction

endpackage

// File: rtl/sramc_capture.sv
module sramc_capture #(
   parameter int AW    = 18,
   parameter int DW    = 16,
   parameter int LANES = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic [AW-1:0]    in_addr,
   input  logic [DW-1:0]    in_wdata,
   input  logic [LANES-1:0] in_mask,
   output logic [AW-1:0]    addr_q,
   output logic [DW-1:0]    wdata_q,
   output logic [LANES-1:0] mask_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         mask_q  <= '0;
      end else if (take) begin
         addr_q  <= in_addr;
         wdata_q <= in_wdata;
         mask_q  <= in_mask;
      end
   end

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
   import sramc_pkg::*;
#(
   parameter int ACC_CYC = 2
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    req,
   input  logic    req_wr,
   input  logic    req_empty,
   output logic    rdy,
   output logic    take,
   output logic    cap,
   output strobe_t strb
);

   localparam int CW = (ACC_CYC < 2) ? 1 : $clog2(ACC_CYC);
   localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

   st_e           st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          last;

   assign last = (cnt_q == LAST);
   assign rdy  = (st_q == ST_IDLE);
   assign take = rdy & req;
   assign cap  = (st_q == ST_RD) & last;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      case (st_q)
         ST_IDLE: begin
            cnt_d = '0;
            if (req) begin
               if (req_empty)   st_d = ST_NOP;
               else if (req_wr) st_d = ST_SETUP;
               else             st_d = ST_RD;
            end
         end
         ST_SETUP: begin
            st_d  = ST_WR;
            cnt_d = '0;
         end
         ST_WR: begin
            if (last) st_d = ST_HOLD;
            else      cnt_d = cnt_q + 1'b1;
         end
         ST_RD: begin
            if (last) st_d = ST_DONE;
            else      cnt_d = cnt_q + 1'b1;
         end
         ST_HOLD, ST_DONE, ST_NOP: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   // strobes come straight from flops: no decode glitches on the pins
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         strb  <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         strb  <= decode_strobes(st_d);
      end
   end

endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
   parameter int DW    = 16,
   parameter int LANES = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             cap,
   input  logic [LANES-1:0] mask_q,
   input  logic [DW-1:0]    dq_in,
   output logic [LANES-1:0] ben_n,
   output logic [DW-1:0]    rd_data
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign ben_n[l] = ~(sel & mask_q[l]);

      always_ff @(posedge clk) begin
         if (!rst_n)
            rd_data[l*8 +: 8] <= '0;
         else if (cap)
            rd_data[l*8 +: 8] <= mask_q[l] ? dq_in[l*8 +: 8] : 8'h00;
      end
   end

endmodule

// File: rtl/sramc_top.sv
module sramc_top
   import sramc_pkg::*;
#(
   parameter int AW      = 18,
   parameter int DW      = 16,
   parameter int ACC_CYC = 2,
   localparam int LANES  = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_wr,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [LANES-1:0] req_mask,
   output logic             rdy,
   output logic             ack,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic [AW-1:0]    sram_addr,
   output logic             sram_ce_n,
   output logic             sram_we_n,
   output logic             sram_oe_n,
   output logic [LANES-1:0] sram_ben_n,
   output logic [DW-1:0]    sram_dq_out,
   output logic             sram_dq_oe,
   input  logic [DW-1:0]    sram_dq_in
);

   if (ACC_CYC < 1) begin : g_bad_acc
      $error("sramc_top: ACC_CYC must be at least 1");
   end
   if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
      $error("sramc_top: DW must be a positive multiple of 8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("sramc_top: AW must be at least 1");
   end

   logic             take, cap;
   strobe_t          strb;
   logic [LANES-1:0] mask_q;

   sramc_seq #(.ACC_CYC(ACC_CYC)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_wr   (req_wr),
      .req_empty(req_mask == '0),
      .rdy      (rdy),
      .take     (take),
      .cap      (cap),
      .strb     (strb)
   );

   sramc_capture #(.AW(AW), .DW(DW), .LANES(LANES)) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .in_addr (req_addr),
      .in_wdata(req_wdata),
      .in_mask (req_mask),
      .addr_q  (sram_addr),
      .wdata_q (sram_dq_out),
      .mask_q  (mask_q)
   );

   sramc_lanes #(.DW(DW), .LANES(LANES)) u_lanes (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (strb.sel),
      .cap    (cap),
      .mask_q (mask_q),
      .dq_in  (sram_dq_in),
      .ben_n  (sram_ben_n),
      .rd_data(rd_data)
   );

   assign sram_ce_n  = ~strb.sel;
   assign sram_we_n  = ~strb.wr;
   assign sram_oe_n  = ~strb.rd;
   assign sram_dq_oe = strb.drv;
   assign ack        = strb.ack;
   assign rd_valid   = strb.rv;

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
   parameter int AW    = 18,
   parameter int DW    = 16,
   parameter int LANES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rdy,
   input logic             ack,
   input logic             rd_valid,
   input logic [AW-1:0]    sram_addr,
   input logic             sram_ce_n,
   input logic             sram_we_n,
   input logic             sram_oe_n,
   input logic [LANES-1:0] sram_ben_n,
   input logic [DW-1:0]    sram_dq_out,
   input logic             sram_dq_oe
);

   // R2: write enable falls only after a cycle of selected, stable address
   a_r2_we_setup: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($past(!sram_ce_n) && $stable(sram_addr)));

   // R2: after write enable rises the address and data are still held
   a_r2_we_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> (!sram_ce_n && sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_out)));

   // R6: bus driven over the whole write pulse
   a_r6_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> (sram_dq_oe && !sram_ce_n));

   // R6: controller and memory never drive together
   a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
      !(sram_dq_oe && !sram_oe_n));

   // R6: a free cycle after output enable before the bus is driven
   a_r6_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!sram_oe_n) |-> !sram_dq_oe);

   // R4: reads keep write enable high with the chip selected
   a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_oe_n |-> (sram_we_n && !sram_ce_n));

   // R4: read data valid only in a completion cycle
   a_r4_rvalid_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ack);

   // R7: completion is a single-cycle pulse and never while idle
   a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);
   a_r7_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> !rdy);

   // R7: held address does not move while busy
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rdy) |-> $stable(sram_addr));

   // R8: the chip is never selected with both lanes off
   a_r8_no_empty_select: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_ce_n |-> (sram_ben_n != '1));

   // R1: idle in reset
   a_r1_reset_idle: assert property (@(posedge clk)
      $past(!rst_n) |-> (sram_ce_n && sram_we_n && sram_oe_n && !sram_dq_oe && !ack && rdy));

endmodule

bind sramc_top sramc_chk #(.AW(AW), .DW(DW), .LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rdy        (rdy),
   .ack        (ack),
   .rd_valid   (rd_valid),
   .sram_addr  (sram_addr),
   .sram_ce_n  (sram_ce_n),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n),
   .sram_ben_n (sram_ben_n),
   .sram_dq_out(sram_dq_out),
   .sram_dq_oe (sram_dq_oe)
);

// File: tb/sim_sramc_top.sv
module sim_sramc_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 18;
   localparam int DW  = 16;
   localparam int ACC = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0, req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_mask = '0;
   logic          rdy, ack, rd_valid;
   logic [DW-1:0] rd_data;
   logic [AW-1:0] sram_addr;
   logic          sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
   logic [1:0]    sram_ben_n;
   logic [DW-1:0] sram_dq_out, sram_dq_in;

   int vectors = 0, errors = 0, model_err = 0;
   int cyc = 0, last_oe_cyc = -100;

   logic [15:0] model_mem [int];
   logic [15:0] ref_mem [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   sramc_top #(.AW(AW), .DW(DW), .ACC_CYC(ACC)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rdy(rdy), .ack(ack), .rd_valid(rd_valid), .rd_data(rd_data),
      .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
      .sram_oe_n(sram_oe_n), .sram_ben_n(sram_ben_n), .sram_dq_out(sram_dq_out),
      .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
   );

   // behavioural memory: drives only selected lanes on a read, filler elsewhere
   function automatic logic [15:0] mem_word(logic [AW-1:0] a);
      if (model_mem.exists(int'(a))) return model_mem[int'(a)];
      return 16'h0000;
   endfunction

   always @(*) begin
      logic [15:0] w;
      w = mem_word(sram_addr);
      for (int l = 0; l < 2; l++) begin
         if (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_ben_n[l])
            sram_dq_in[l*8 +: 8] = w[l*8 +: 8];
         else
            sram_dq_in[l*8 +: 8] = 8'hA5;
      end
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (sram_dq_oe && !sram_oe_n && !sram_ce_n) model_err <= model_err + 1;
         if (!sram_ce_n && !sram_we_n) begin
            logic [15:0] w;
            if (!sram_dq_oe) model_err <= model_err + 1;
            w = mem_word(sram_addr);
            for (int l = 0; l < 2; l++)
               if (!sram_ben_n[l]) w[l*8 +: 8] = sram_dq_out[l*8 +: 8];
            model_mem[int'(sram_addr)] = w;
         end
      end
   end

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [15:0] ref_read(logic [AW-1:0] a, logic [1:0] m);
      logic [15:0] w, r;
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
      r = 16'h0000;
      for (int l = 0; l < 2; l++) if (m[l]) r[l*8 +: 8] = w[l*8 +: 8];
      return r;
   endfunction

   task automatic ref_write(logic [AW-1:0] a, logic [15:0] d, logic [1:0] m);
      logic [15:0] w;
      w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
      for (int l = 0; l < 2; l++) if (m[l]) w[l*8 +: 8] = d[l*8 +: 8];
      ref_mem[int'(a)] = w;
   endtask

   task automatic run_op(input bit wr, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic [1:0] m);
      int n = 0, we_cnt = 0, we_first = 0, oe_cnt = 0, oe_first = 0;
      int ce_cnt = 0, drv_first = 0, ack_n = 0;
      bit hold_bad = 0, busy_bad = 0, ben_bad = 0, rv_seen = 0, drv_bad = 0;
      logic [15:0] got = '0;
      @(negedge clk);
      check(rdy === 1'b1, "R7 ready before request", int'(rdy), 1);
      req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk); #1;
      // junk while busy must be ignored
      req_addr = ~a; req_wdata = ~d; req_mask = 2'b11; req_wr = ~wr;
      while (ack_n == 0 && n < ACC + 8) begin
         @(negedge clk);
         n++;
         if (rdy) busy_bad = 1;
         if (!sram_ce_n) begin
            ce_cnt++;
            if (sram_addr !== a) hold_bad = 1;
            if (sram_ben_n !== ~m) ben_bad = 1;
         end
         if (!sram_we_n) begin we_cnt++; if (we_first == 0) we_first = n; end
         if (!sram_oe_n) begin oe_cnt++; if (oe_first == 0) oe_first = n; last_oe_cyc = cyc; end
         if (sram_dq_oe) begin
            if (drv_first == 0) begin
               drv_first = n;
               check(cyc - last_oe_cyc >= 2, "R6 turnaround gap", cyc - last_oe_cyc, 2);
            end
            if (sram_dq_out !== d || !wr) drv_bad = 1;
         end
         if (ack) begin
            ack_n = n; rv_seen = rd_valid; got = rd_data;
            req = 1'b0;
         end
      end
      check(!busy_bad, "R7 rdy low while busy", int'(busy_bad), 0);
      check(!hold_bad, "R7 held address", int'(hold_bad), 0);
      if (m == 2'b00) begin
         check(ack_n == 1, "R8 empty ack cycle", ack_n, 1);
         check(ce_cnt == 0 && we_cnt == 0 && oe_cnt == 0, "R8 no strobes", ce_cnt + we_cnt + oe_cnt, 0);
         check(!rv_seen, "R8 no rd_valid", int'(rv_seen), 0);
      end else if (wr) begin
         check(ack_n == ACC + 2, "R2 write ack cycle", ack_n, ACC + 2);
         check(we_cnt == ACC && we_first == 2, "R2 we window", we_cnt * 16 + we_first, ACC * 16 + 2);
         check(ce_cnt == ACC + 2, "R2 ce window", ce_cnt, ACC + 2);
         check(!ben_bad, "R3 byte enables", int'(sram_ben_n), int'(~m));
         check(drv_first == 1 && !drv_bad && oe_cnt == 0, "R6 write drive", drv_first, 1);
         check(!rv_seen, "R2 no rd_valid on write", int'(rv_seen), 0);
         ref_write(a, d, m);
      end else begin
         check(ack_n == ACC + 1 && rv_seen, "R4 read ack cycle", ack_n, ACC + 1);
         check(oe_cnt == ACC && oe_first == 1 && we_cnt == 0, "R4 oe window", oe_cnt * 16 + oe_first, ACC * 16 + 1);
         check(drv_first == 0, "R6 no drive on read", drv_first, 0);
         check(!ben_bad, "R3 byte enables on read", int'(sram_ben_n), int'(~m));
         check(got === ref_read(a, m), "R5 read data", int'(got), int'(ref_read(a, m)));
      end
   endtask

   initial begin
      repeat (ACC + 160000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: act=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [AW-1:0] pool [16];
      int seed;
      seed = 32'h5A3C;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(sram_ce_n && sram_we_n && sram_oe_n && sram_ben_n == 2'b11 &&
            !sram_dq_oe && !ack && !rd_valid && rdy, "R1 reset state",
            {sram_ce_n, sram_we_n, sram_oe_n, sram_ben_n, sram_dq_oe, ack, rd_valid, rdy}, 9'b111110001);
      rst_n = 1'b1;

      // directed corners
      run_op(1, 18'h00000, 16'h1234, 2'b11);
      run_op(1, 18'h3FFFF, 16'hBEEF, 2'b11);
      run_op(0, 18'h3FFFF, 16'h0000, 2'b11);
      run_op(1, 18'h00000, 16'hAB00 | 16'h00CD, 2'b01);   // R3 low byte only
      run_op(0, 18'h00000, 16'h0000, 2'b11);
      run_op(1, 18'h00000, 16'h77EE, 2'b10);              // R3 high byte only
      run_op(0, 18'h00000, 16'h0000, 2'b11);
      run_op(0, 18'h00000, 16'h0000, 2'b01);              // R5 high lane zero
      run_op(0, 18'h3FFFF, 16'h0000, 2'b10);              // R5 low lane zero
      run_op(0, 18'h3FFFF, 16'h0000, 2'b00);              // R8 after read
      run_op(1, 18'h12345, 16'hFFFF, 2'b00);              // R8 empty write
      run_op(0, 18'h12345, 16'h0000, 2'b11);              // nothing written there
      run_op(1, 18'h12345, 16'h5555, 2'b11);              // write after read

      for (int i = 0; i < 16; i++) pool[i] = AW'($urandom);
      for (int i = 0; i < 300; i++) begin
         int k;
         logic [1:0] m;
         k = $urandom % 8;
         m = (k == 0) ? 2'b00 : 2'(1 + ($urandom % 3));
         run_op(k < 4, pool[$urandom % 16], 16'($urandom), m);
      end

      check(model_err == 0, "R6 memory strobe rules", model_err, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule